// File: doc/BRIEF.md
# Flash Power-Mode and Reset Controller

This block is the control wrapper that sits around a parallel flash array. It samples four active-low controls once per clock: chip select, read strobe, write strobe and a combined reset/power-down line. From them it decides whether the data bus is driven, and whether the device is active, in standby or in deep power-down. It also runs the command front end. A change to the array starts only after a setup byte and a confirm byte have been written in turn. A down-counter stands in for the program or erase time.

Standby is held off while an operation is in flight. A short pulse on the reset line lets the operation run on. Holding the line low long enough aborts the operation and marks the location as bad. Each falling edge of the reset line wipes the status flags. After the line is released, read data is not reported valid until a recovery count, set on an input port, has elapsed. An asynchronous power-on reset stands for power being removed and restored.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: With `rp_n` high, `ce_n` high and no operation running, `pwr_state` is 1 (standby) and `dq_oe` is 0, whatever `oe_n` is. With `ce_n` low and `rp_n` high, `pwr_state` is 0 (active).
- R2: While an operation runs (`sts_ready`=0) and `rp_n` is high, `pwr_state` stays 0 (active) even with `ce_n` high.
- R3: While `rp_n` is low, `pwr_state` is 2 (deep power-down), and `dq_oe` and `rd_valid` are 0.
- R4: The clock edge that first samples `rp_n` low clears `sts_abort`. Power-on reset clears every flag.
- R5: If `rp_n` is sampled low on ABORT_MIN consecutive edges while an operation runs, the last of those edges ends the operation and sets `sts_ready`, `sts_abort` and `loc_invalid` to 1. A shorter low pulse leaves the operation running.
- R6: After power-on reset, and on any edge that samples `rp_n` low while no operation runs, the command state returns to read-array (`read_array`=1).
- R7: A write is taken only on the first edge at which `ce_n`, `we_n` are both low and `rp_n` is high. If either strobe is high, the bus byte has no effect.
- R8: An operation starts (`sts_ready` falls) only when the confirm byte 8'hD0 is written directly after the setup byte 8'h40. On its own, a confirm byte is ignored.
- R9: After `rp_n` is released, `rd_valid` (`dq_oe` and recovery done) stays 0 until `rp_n` has been sampled high on `rec_len` edges.
- R10: Any byte other than 8'hD0 written after the setup byte cancels the sequence and returns to read-array with no operation started.
- R11: An operation lasts OP_CYCLES edges counted from the confirm edge. On completion, `sts_ready` returns to 1 and `loc_invalid` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rp_n | input | 1 | Reset / deep power-down request, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| din | input | DW | Command byte on the bus |
| rec_len | input | RCW | Recovery count after reset release |
| dq_oe | output | 1 | Data bus driven |
| rd_valid | output | 1 | Read data valid |
| pwr_state | output | 2 | 0 active, 1 standby, 2 deep power-down |
| read_array | output | 1 | Command state is read-array |
| sts_ready | output | 1 | Status: 1 ready, 0 busy |
| sts_abort | output | 1 | Status: sticky abort error |
| loc_invalid | output | 1 | Last operation was aborted, location contents bad |

## Verification
The assertions assume three things about the inputs. `rec_len` is held constant while a recovery count runs. ABORT_MIN is at least 2, so the status clear on the first low edge never coincides with an abort. Abort and normal completion never fall on the same edge. The stimulus sets `rec_len` once after power-on. It drives every control at the falling clock edge, and it times reset pulses during operations so that they end well before or well after the abort threshold, and well clear of the completion edge. Random phases vary only the chip select and read strobe with the device idle and recovered, plus random non-confirm bytes after a setup.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_DEEP    = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    M_READ  = 2'd0,
    M_SETUP = 2'd1,
    M_BUSY  = 2'd2
  } mode_e;

  // Deep power-down wins; an operation in flight keeps the part active.
  function automatic pwr_e pwr_decide(logic rp_n, logic ce_n, logic busy);
    if (!rp_n)             return PWR_DEEP;
    else if (!ce_n || busy) return PWR_ACTIVE;
    else                   return PWR_STANDBY;
  endfunction

  function automatic logic wr_level(logic rp_n, logic ce_n, logic we_n);
    return rp_n & ~ce_n & ~we_n;
  endfunction

endpackage

// File: rtl/fpc_cmd.sv
module fpc_cmd
  import flash_pwr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int OP_CYCLES = 20,
  parameter int ABORT_MIN = 6,
  parameter logic [DW-1:0] SETUP   = 8'h40,
  parameter logic [DW-1:0] CONFIRM = 8'hD0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rp_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  output mode_e         mode,
  output logic          sts_abort,
  output logic          loc_invalid,
  output logic          wr_ev,
  output logic          abort_ev
);
  localparam int OPW = $clog2(OP_CYCLES + 1);
  localparam int ABW = $clog2(ABORT_MIN + 1);

  logic           wr_act, wr_act_q, rp_q, fall_ev;
  logic [OPW-1:0] op_cnt;
  logic [ABW-1:0] low_cnt;

  assign wr_act   = wr_level(rp_n, ce_n, we_n);
  assign wr_ev    = wr_act & ~wr_act_q;
  assign fall_ev  = rp_q & ~rp_n;
  assign abort_ev = (mode == M_BUSY) & ~rp_n & (low_cnt >= ABW'(ABORT_MIN - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode        <= M_READ;
      wr_act_q    <= 1'b0;
      rp_q        <= 1'b0;
      low_cnt     <= '0;
      op_cnt      <= '0;
      sts_abort   <= 1'b0;
      loc_invalid <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rp_q     <= rp_n;
      if (rp_n)                             low_cnt <= '0;
      else if (low_cnt != ABW'(ABORT_MIN))  low_cnt <= low_cnt + 1'b1;
      if (fall_ev) sts_abort <= 1'b0;
      case (mode)
        M_READ: if (wr_ev && din == SETUP) mode <= M_SETUP;
        M_SETUP: begin
          if (!rp_n) mode <= M_READ;
          else if (wr_ev) begin
            if (din == CONFIRM) begin
              mode   <= M_BUSY;
              op_cnt <= OPW'(OP_CYCLES);
            end else begin
              mode <= M_READ;
            end
          end
        end
        M_BUSY: begin
          if (abort_ev) begin
            mode        <= M_READ;
            sts_abort   <= 1'b1;
            loc_invalid <= 1'b1;
          end else if (op_cnt == OPW'(1)) begin
            mode        <= M_READ;
            loc_invalid <= 1'b0;
          end else begin
            op_cnt <= op_cnt - 1'b1;
          end
        end
        default: mode <= M_READ;
      endcase
    end
  end

  // R4: first low sample of reset wipes the abort flag
  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
    fall_ev |=> !sts_abort);
  // R5: a long enough reset pulse ends the operation with an error
  assert_abort_R5: assert property (@(posedge clk) disable iff (!por_n)
    abort_ev |=> (mode == M_READ) && sts_abort && loc_invalid);
  // R6: reset with no operation running forces read-array
  assert_read_mode_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!rp_n && mode != M_BUSY) |=> mode == M_READ);
  // R7: without a write event the setup state is never reached from read-array
  assert_write_gate_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_READ && !wr_ev) |=> mode != M_SETUP);
  // R8: an operation can only start from the setup state
  assert_two_step_R8: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_READ) |=> mode != M_BUSY);
  // R10: a wrong second byte cancels the sequence
  assert_cancel_R10: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_SETUP && wr_ev && din != CONFIRM) |=> mode == M_READ);
endmodule

// File: rtl/fpc_recovery.sv
module fpc_recovery #(
  parameter int RCW = 6
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rp_n,
  input  logic [RCW-1:0] rec_len,
  output logic           rec_done
);
  logic [RCW-1:0] cnt;

  assign rec_done = (cnt >= rec_len);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt <= '0;
    else if (!rp_n)          cnt <= '0;
    else if (cnt < rec_len)  cnt <= cnt + 1'b1;
  end

  // R9: no valid reads on the cycle after any reset sample when recovery is needed
  assert_recovery_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!rp_n && rec_len != '0) |=> !rec_done);
endmodule

// File: rtl/fpc_power.sv
module fpc_power
  import flash_pwr_pkg::*;
(
  input  logic rp_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic busy,
  input  logic rec_done,
  output pwr_e pwr,
  output logic dq_oe,
  output logic rd_valid
);
  assign pwr      = pwr_decide(rp_n, ce_n, busy);
  assign dq_oe    = rp_n & ~ce_n & ~oe_n;
  assign rd_valid = dq_oe & rec_done;
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RCW       = 6,
  parameter int OP_CYCLES = 20,
  parameter int ABORT_MIN = 6
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rp_n,
  input  logic           ce_n,
  input  logic           oe_n,
  input  logic           we_n,
  input  logic [DW-1:0]  din,
  input  logic [RCW-1:0] rec_len,
  output logic           dq_oe,
  output logic           rd_valid,
  output logic [1:0]     pwr_state,
  output logic           read_array,
  output logic           sts_ready,
  output logic           sts_abort,
  output logic           loc_invalid
);
  mode_e mode;
  pwr_e  pwr;
  logic  busy, rec_done, wr_ev, abort_ev;

  fpc_cmd #(.DW(DW), .OP_CYCLES(OP_CYCLES), .ABORT_MIN(ABORT_MIN)) u_cmd (
    .clk(clk), .por_n(por_n), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .din(din),
    .mode(mode), .sts_abort(sts_abort), .loc_invalid(loc_invalid),
    .wr_ev(wr_ev), .abort_ev(abort_ev)
  );

  fpc_recovery #(.RCW(RCW)) u_rec (
    .clk(clk), .por_n(por_n), .rp_n(rp_n), .rec_len(rec_len), .rec_done(rec_done)
  );

  fpc_power u_pwr (
    .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy), .rec_done(rec_done),
    .pwr(pwr), .dq_oe(dq_oe), .rd_valid(rd_valid)
  );

  assign busy       = (mode == M_BUSY);
  assign sts_ready  = ~busy;
  assign read_array = (mode == M_READ);
  assign pwr_state  = pwr;

  // R1: idle and deselected means standby with the bus released
  assert_standby_R1: assert property (@(posedge clk) disable iff (!por_n)
    (rp_n && ce_n && sts_ready) |-> (pwr_state == 2'd1) && !dq_oe);
  // R2: an operation in flight keeps the part active
  assert_busy_active_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!sts_ready && rp_n) |-> pwr_state == 2'd0);
  // R3: reset low means deep power-down with nothing driven
  assert_deep_R3: assert property (@(posedge clk) disable iff (!por_n)
    !rp_n |-> (pwr_state == 2'd2) && !dq_oe && !rd_valid);
  // R11: completion without abort clears the bad-location flag
  assert_complete_R11: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !abort_ev) |=> (busy || !loc_invalid));
endmodule

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
  localparam int DW = 8, RCW = 6, OPC = 20, ABM = 6, RLEN = 5;
  localparam logic [7:0] SETUP = 8'h40, CONFIRM = 8'hD0;

  logic clk = 1'b0, por_n = 1'b0, rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0]  din = '0;
  logic [RCW-1:0] rec_len = RCW'(RLEN);
  logic dq_oe, rd_valid, read_array, sts_ready, sts_abort, loc_invalid;
  logic [1:0] pwr_state;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_pwr_ctrl #(.DW(DW), .RCW(RCW), .OP_CYCLES(OPC), .ABORT_MIN(ABM)) i_flash_pwr_ctrl (
    .clk(clk), .por_n(por_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .din(din), .rec_len(rec_len), .dq_oe(dq_oe), .rd_valid(rd_valid),
    .pwr_state(pwr_state), .read_array(read_array), .sts_ready(sts_ready),
    .sts_abort(sts_abort), .loc_invalid(loc_invalid)
  );

  function automatic logic [1:0] exp_pwr(logic rp, logic ce, logic bsy);
    if (!rp) return 2'd2;
    if (ce && !bsy) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; din = d;
    tick();
    ce_n = 1'b1; we_n = 1'b1;
    tick();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // reset state
    chk("R4 reset abort", sts_abort, 0);
    chk("R4 reset invalid", loc_invalid, 0);
    chk("R6 reset read", read_array, 1);
    chk("R1 reset pwr", pwr_state, 1);
    ticks(2);
    por_n = 1'b1;
    ticks(RLEN + 1);

    // R1 standby independent of read strobe
    oe_n = 1'b0; #1;
    chk("R1 standby dq_oe", dq_oe, 0);
    chk("R1 standby pwr", pwr_state, 1);
    ce_n = 1'b0; #1;
    chk("R1 active pwr", pwr_state, 0);
    chk("R1 read drive", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    tick();

    // R3 / R9 deep power-down and recovery
    rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R3 deep pwr", pwr_state, 2);
    chk("R3 deep dq_oe", dq_oe, 0);
    tick();
    rp_n = 1'b1; #1;
    chk("R9 dq_oe after release", dq_oe, 1);
    chk("R9 not valid at release", rd_valid, 0);
    ticks(RLEN - 1);
    chk("R9 not valid before count", rd_valid, 0);
    tick();
    chk("R9 valid after count", rd_valid, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    tick();

    // R7 write gating
    ce_n = 1'b1; we_n = 1'b0; din = SETUP; tick();
    we_n = 1'b1; tick();
    chk("R7 ce high blocks", read_array, 1);
    ce_n = 1'b0; we_n = 1'b1; tick();
    ce_n = 1'b1; tick();
    chk("R7 we high blocks", read_array, 1);
    rp_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; tick();
    ce_n = 1'b1; we_n = 1'b1; rp_n = 1'b1; tick();
    chk("R7 reset low blocks", read_array, 1);
    ticks(RLEN);

    // R8 lone confirm ignored
    wr(CONFIRM);
    chk("R8 lone confirm", sts_ready, 1);
    chk("R8 lone confirm mode", read_array, 1);

    // R6 reset during setup returns to read-array
    wr(SETUP);
    chk("R7 setup taken", read_array, 0);
    rp_n = 1'b0; tick();
    chk("R6 reset to read", read_array, 1);
    rp_n = 1'b1; ticks(RLEN);

    // R8 / R11 / R2 full operation
    wr(SETUP);
    wr(CONFIRM);
    chk("R8 op started", sts_ready, 0);
    chk("R2 active while busy", pwr_state, 0);
    ticks(OPC - 2);
    chk("R11 still busy", sts_ready, 0);
    tick();
    chk("R11 done", sts_ready, 1);
    chk("R11 read after done", read_array, 1);
    chk("R1 standby after done", pwr_state, 1);

    // R5 abort with long reset pulse
    wr(SETUP);
    wr(CONFIRM);
    rp_n = 1'b0;
    ticks(ABM - 1);
    chk("R5 busy before threshold", sts_ready, 0);
    chk("R3 deep while busy", pwr_state, 2);
    tick();
    chk("R5 aborted ready", sts_ready, 1);
    chk("R5 abort flag", sts_abort, 1);
    chk("R5 invalid flag", loc_invalid, 1);
    rp_n = 1'b1; tick();
    chk("R6 read after abort", read_array, 1);
    chk("R4 abort sticky", sts_abort, 1);
    rp_n = 1'b0; tick();
    chk("R4 cleared on reset", sts_abort, 0);
    chk("R4 invalid kept", loc_invalid, 1);
    rp_n = 1'b1; ticks(RLEN);

    // R5 short pulse does not abort; R11 clears invalid
    wr(SETUP);
    wr(CONFIRM);
    rp_n = 1'b0; ticks(3);
    rp_n = 1'b1;
    chk("R5 short pulse keeps op", sts_ready, 0);
    ticks(OPC - 5);
    chk("R11 busy after short pulse", sts_ready, 0);
    tick();
    chk("R11 done after short pulse", sts_ready, 1);
    chk("R11 invalid cleared", loc_invalid, 0);
    chk("R5 no abort flag", sts_abort, 0);
    ticks(RLEN);

    // R10 random wrong confirm bytes
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (b == CONFIRM) b = b ^ 8'h01;
      wr(SETUP);
      wr(b);
      chk("R10 cancel mode", read_array, 1);
      chk("R10 cancel no op", sts_ready, 1);
    end

    // R1 random chip select / read strobe while idle
    for (int i = 0; i < 150; i++) begin
      logic c, o;
      c = 1'($urandom); o = 1'($urandom);
      ce_n = c; oe_n = o; #1;
      chk("R1 random pwr", pwr_state, exp_pwr(1'b1, c, 1'b0));
      chk("R1 random dq_oe", dq_oe, !c && !o);
      chk("R9 random rd_valid", rd_valid, !c && !o);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule